// File: doc/BRIEF.md
# Load-Align Shift-Insert Accumulator

This block is a 64-bit destination register that gathers narrow memory elements into one wide word. Each time a load completes, the register moves its present contents toward the least significant end by one element width and drops the freshly loaded element into the most significant position. Several loads in a row therefore pack successive elements into one word. The first element loaded ends up in the lowest bits, and bits not yet pushed out keep their old value.

The load strobe comes with a size select, which picks byte or halfword elements, and a 16-bit data bus. A synchronous preset port writes the whole register. Address generation and the memory are outside the block.

Each clock cycle the control logic decodes one operation, and that operation sets the next register value:
- HOLD: keep the contents.
- PRESET: take the preset word.
- INS_BYTE: shift by 8 and insert a byte.
- INS_HALF: shift by 16 and insert a halfword.

The register can only move from its current value to the value that the decoded operation selects. Reset moves it to zero from any operation.

Top module: `ldalign_acc`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `acc_q` becomes zero after that edge. This takes priority over every other input.
- R2: A byte load (`ld_valid`=1, `ld_size`=2'b00, `wr_en`=0) sets `acc_q` to the old contents shifted right by 8. `ld_data[7:0]` goes into bits 63:56.
- R3: A halfword load (`ld_valid`=1, `ld_size`=2'b01, `wr_en`=0) sets `acc_q` to the old contents shifted right by 16. `ld_data[15:0]` goes into bits 63:48. `ld_data[7:0]` carries the byte from the lower memory address, so that byte lands in bits 55:48.
- R4: Bits not yet shifted out keep their earlier value. Preset to all ones, then byte loads of 0x01 and 0x02, give 0x0201ffffffffffff.
- R5: Four halfword loads of 0x0201, 0x0403, 0x0605 and 0x0807, in that order, leave 0x0807060504030201.
- R6: With `wr_en`=1, `acc_q` takes `wr_data` at the next edge.
- R7: If `wr_en` and `ld_valid` are both high in one cycle, the preset wins and the load is dropped.
- R8: A load with `ld_size` equal to 2'b10 or 2'b11 leaves `acc_q` unchanged.
- R9: When `ld_valid` and `wr_en` are both low, `acc_q` is unchanged whatever `ld_size` and `ld_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Load completion strobe |
| ld_size | input | 2 | Element size: 00 byte, 01 halfword, others unsupported |
| ld_data | input | 16 | Loaded element; bits 7:0 come from the lower address |
| wr_en | input | 1 | Preset write enable |
| wr_data | input | 64 | Preset value |
| acc_q | output | 64 | Accumulator contents |

## Verification
The main function is exercised with several input patterns:
- Runs of byte loads and runs of halfword loads, both drawn from a memory model that holds ascending byte values and starting from an all-ones preset. Remaining ones bits show how far each run has shifted, and the halfword run shows whether the two bytes of a halfword are swapped.
- Mixed byte and halfword sequences, which separate a correct per-load shift amount from a fixed one.
- Collisions of preset and load, unsupported size codes, and idle cycles carrying junk data. These confirm priority and hold behaviour.
- A long random stream, including resets in the middle of a sequence, compared on every clock against a behavioural model.

// File: rtl/ldalign_pkg.sv
package ldalign_pkg;

    // Operation selected for the accumulator in the current cycle.
    typedef enum logic [1:0] {
        OP_HOLD     = 2'd0,
        OP_PRESET   = 2'd1,
        OP_INS_BYTE = 2'd2,
        OP_INS_HALF = 2'd3
    } acc_op_e;

    // Size-select encodings seen at the port.
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    // Number of supported element sizes (byte, halfword).
    localparam int NUM_SIZES = 2;

endpackage

// File: rtl/ldalign_decode.sv
module ldalign_decode
    import ldalign_pkg::*;
(
    input  logic       wr_en,
    input  logic       ld_valid,
    input  logic [1:0] ld_size,
    output acc_op_e    op
);

    // Preset outranks any load; unsupported size codes decay to HOLD.
    always_comb begin
        op = OP_HOLD;
        if (wr_en) begin
            op = OP_PRESET;
        end else if (ld_valid) begin
            unique case (ld_size)
                SZ_BYTE: op = OP_INS_BYTE;
                SZ_HALF: op = OP_INS_HALF;
                default: op = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/ldalign_insert.sv
module ldalign_insert
    import ldalign_pkg::*;
#(
    parameter int REG_W  = 64,
    parameter int BYTE_W = 8,
    localparam int ELEM_MAX = BYTE_W << (NUM_SIZES - 1)
) (
    input  logic [REG_W-1:0]                cur,
    input  logic [ELEM_MAX-1:0]             data,
    output logic [NUM_SIZES-1:0][REG_W-1:0] cand
);

    // One shift-and-insert candidate per element size: size k is BYTE_W<<k bits.
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int EW = BYTE_W << k;
        assign cand[k] = {data[EW-1:0], cur[REG_W-1:EW]};
    end

endmodule

// File: rtl/ldalign_next.sv
module ldalign_next
    import ldalign_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  acc_op_e                         op,
    input  logic [REG_W-1:0]                cur,
    input  logic [REG_W-1:0]                preset,
    input  logic [NUM_SIZES-1:0][REG_W-1:0] cand,
    output logic [REG_W-1:0]                nxt
);

    always_comb begin
        unique case (op)
            OP_PRESET:   nxt = preset;
            OP_INS_BYTE: nxt = cand[0];
            OP_INS_HALF: nxt = cand[1];
            default:     nxt = cur;
        endcase
    end

endmodule

// File: rtl/ldalign_acc.sv
module ldalign_acc
    import ldalign_pkg::*;
#(
    parameter int REG_W  = 64,
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_valid,
    input  logic [1:0]            ld_size,
    input  logic [2*BYTE_W-1:0]   ld_data,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_data,
    output logic [REG_W-1:0]      acc_q
);

    acc_op_e                         op;
    logic [REG_W-1:0]                acc_r;
    logic [REG_W-1:0]                acc_nxt;
    logic [NUM_SIZES-1:0][REG_W-1:0] cand;

    ldalign_decode u_decode (
        .wr_en    (wr_en),
        .ld_valid (ld_valid),
        .ld_size  (ld_size),
        .op       (op)
    );

    ldalign_insert #(
        .REG_W  (REG_W),
        .BYTE_W (BYTE_W)
    ) u_insert (
        .cur  (acc_r),
        .data (ld_data),
        .cand (cand)
    );

    ldalign_next #(
        .REG_W (REG_W)
    ) u_next (
        .op     (op),
        .cur    (acc_r),
        .preset (wr_data),
        .cand   (cand),
        .nxt    (acc_nxt)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r <= '0;
        end else begin
            acc_r <= acc_nxt;
        end
    end

    // Output process.
    always_comb begin
        acc_q = acc_r;
    end

endmodule

// File: rtl/ldalign_acc_chk.sv
module ldalign_acc_chk #(
    parameter int REG_W  = 64,
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ld_valid,
    input logic [1:0]          ld_size,
    input logic [2*BYTE_W-1:0] ld_data,
    input logic                wr_en,
    input logic [REG_W-1:0]    wr_data,
    input logic [REG_W-1:0]    acc_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> acc_q == '0);

    p_byte_ins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !wr_en && ld_size == 2'b00) |=>
            acc_q == {$past(ld_data[BYTE_W-1:0]), $past(acc_q[REG_W-1:BYTE_W])});

    p_half_ins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !wr_en && ld_size == 2'b01) |=>
            acc_q == {$past(ld_data), $past(acc_q[REG_W-1:2*BYTE_W])});

    p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> acc_q == $past(wr_data));

    p_preset_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ld_valid) |=> acc_q == $past(wr_data));

    p_bad_size_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !wr_en && ld_size[1]) |=> $stable(acc_q));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid && !wr_en) |=> $stable(acc_q));

endmodule

bind ldalign_acc ldalign_acc_chk #(
    .REG_W  (REG_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_size  (ld_size),
    .ld_data  (ld_data),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .acc_q    (acc_q)
);

// File: tb/ldalign_acc_bench.sv
module ldalign_acc_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_valid;
    logic [1:0]  ld_size;
    logic [15:0] ld_data;
    logic        wr_en;
    logic [63:0] wr_data;
    logic [63:0] acc_q;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] model = '0;
    bit done = 0;

    always #10 clk = ~clk;

    ldalign_acc u_ldalign_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_size  (ld_size),
        .ld_data  (ld_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .acc_q    (acc_q)
    );

    // Memory model: byte at address a holds a+1.
    function automatic logic [7:0] mem_b(int a);
        return 8'(a + 1);
    endfunction

    function automatic logic [15:0] mem_h(int a);
        return {mem_b(a + 1), mem_b(a)};
    endfunction

    task automatic check(input logic [63:0] exp, input string req);
        n_chk++;
        if (acc_q !== exp) begin
            n_err++;
            $display("FAIL %s: acc_q=%h expected %h", req, acc_q, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge.
    task automatic step(input logic rs, input logic we, input logic [63:0] wd,
                        input logic lv, input logic [1:0] sz, input logic [15:0] ld,
                        input string req);
        rst_n = rs; wr_en = we; wr_data = wd;
        ld_valid = lv; ld_size = sz; ld_data = ld;
        @(posedge clk);
        if (!rs)                   model = '0;
        else if (we)               model = wd;
        else if (lv && sz == 2'b00) model = {ld[7:0], model[63:8]};
        else if (lv && sz == 2'b01) model = {ld, model[63:16]};
        @(negedge clk);
        check(model, req);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: acc_q=%h expected run to finish", acc_q);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        ld_valid = 1'b0; ld_size = 2'b00; ld_data = '0;
        @(negedge clk);
        // R1: reset state
        step(0, 0, 64'h0, 0, 2'b00, 16'h0, "R1");
        step(0, 1, 64'hdead_beef_0123_4567, 1, 2'b01, 16'hffff, "R1");
        check(64'h0, "R1");

        // R6 preset, R4 partial fill, R2 byte run
        step(1, 1, '1, 0, 2'b00, 16'h0, "R6");
        check(64'hffff_ffff_ffff_ffff, "R6");
        for (int p = 0; p < 2; p++) step(1, 0, '0, 1, 2'b00, {8'h5a, mem_b(p)}, "R2");
        check(64'h0201_ffff_ffff_ffff, "R4");
        for (int p = 2; p < 4; p++) step(1, 0, '0, 1, 2'b00, {8'ha5, mem_b(p)}, "R2");
        check(64'h0403_0201_ffff_ffff, "R2");

        // R3/R5 halfword run, little-endian assembly
        step(1, 1, '1, 0, 2'b00, 16'h0, "R6");
        step(1, 0, '0, 1, 2'b01, mem_h(0), "R3");
        check(64'h0201_ffff_ffff_ffff, "R3");
        for (int p = 2; p < 8; p += 2) step(1, 0, '0, 1, 2'b01, mem_h(p), "R3");
        check(64'h0807_0605_0403_0201, "R5");

        // Mixed sizes: byte then halfword
        step(1, 1, '1, 0, 2'b00, 16'h0, "R6");
        step(1, 0, '0, 1, 2'b00, mem_h(0), "R2");
        step(1, 0, '0, 1, 2'b01, mem_h(4), "R3");
        check(64'h0605_01ff_ffff_ffff, "R3");

        // R7 preset wins over load
        step(1, 1, 64'h1122_3344_5566_7788, 1, 2'b00, 16'h00aa, "R7");
        check(64'h1122_3344_5566_7788, "R7");
        step(1, 1, 64'h0f0f_0f0f_0f0f_0f0f, 1, 2'b01, 16'hbbcc, "R7");
        check(64'h0f0f_0f0f_0f0f_0f0f, "R7");

        // R8 unsupported sizes hold
        step(1, 0, '0, 1, 2'b10, 16'h1234, "R8");
        step(1, 0, '0, 1, 2'b11, 16'h5678, "R8");
        check(64'h0f0f_0f0f_0f0f_0f0f, "R8");

        // R9 idle with junk hold
        step(1, 0, 64'hffff_0000_ffff_0000, 0, 2'b00, 16'hcafe, "R9");
        step(1, 0, '0, 0, 2'b01, 16'hbeef, "R9");
        check(64'h0f0f_0f0f_0f0f_0f0f, "R9");

        // R1 reset in mid-sequence
        step(1, 0, '0, 1, 2'b00, 16'h0077, "R2");
        step(0, 0, '0, 1, 2'b01, 16'h9999, "R1");
        check(64'h0, "R1");

        // Random stream against the model
        for (int i = 0; i < 2000; i++) begin
            logic rs, we, lv;
            logic [1:0] sz;
            rs = ($urandom_range(0, 63) != 0);
            we = ($urandom_range(0, 7) == 0);
            lv = ($urandom_range(0, 3) != 0);
            sz = 2'($urandom_range(0, 3));
            step(rs, we, {$urandom, $urandom}, lv, sz, 16'($urandom),
                 !rs ? "R1" : we ? "R6" : !lv ? "R9" : sz == 2'b00 ? "R2" :
                 sz == 2'b01 ? "R3" : "R8");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule